// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block keeps four sticky event flags for a set of timers and turns them into interrupt requests. Each flag has its own bit position, which software reads back over a simple bus port. The four flags are: an input capture on counter 1, a compare match on counter 2, an overflow on counter 0 and a compare match on counter 0. A timer raises a flag with a one-cycle event pulse.

A flag is cleared in one of two ways. When the processor runs that source's vector, a per-source acknowledge pulse clears it. Software can also write a one to the flag's bit. Each source drives its own interrupt request, which is the logical AND of the global enable, that source's enable and its flag.

The counter-0 overflow flag has two possible set conditions:
- In normal counting it is set by a wrap past the maximum count.
- In pulse-width-modulation mode it is set when the counter advances away from zero.

Prioritisation between sources is left to the consumer of the request vector.

Top module: `timer_irq_flags`

## Requirements
- R1: After a synchronous reset, all four flags read as zero and every request output is zero.
- R2: The bit layout is fixed: bit 3 is capture-1, bit 2 is compare-2, bit 1 is overflow-0 and bit 0 is compare-0. A pulse on the capture-1, compare-2 or compare-0 event input sets the matching bit, which reads as one after the next rising clock edge.
- R3: With `pwm_mode_i` low, `ovf0_wrap_i` sets bit 1. A pulse on `ovf0_from_zero_i` alone leaves bit 1 unchanged.
- R4: With `pwm_mode_i` high, `ovf0_from_zero_i` sets bit 1. A pulse on `ovf0_wrap_i` alone leaves bit 1 unchanged.
- R5: A bus write clears every flag whose data bit is one, from the next edge on. Flags whose data bit is zero keep their value.
- R6: A one on bit n of `ack_i` clears flag n at the next edge.
- R7: If a set event and a clear (by write, by acknowledge or both) hit the same flag in one cycle, the flag is one after that edge.
- R8: `irq_o[n]` is one exactly when `gie_i`, `src_en_i[n]` and flag n are all one. It follows the enables in the same cycle.
- R9: Read bits 7 to 4 are always zero, and writes to them change nothing.
- R10: With no event, write or acknowledge addressed to it, a flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie_i | input | 1 | Global interrupt enable |
| src_en_i | input | 4 | Per-source interrupt enables, same bit layout as the flags |
| cap1_evt_i | input | 1 | Counter-1 input capture event pulse |
| cmp2_evt_i | input | 1 | Counter-2 compare match event pulse |
| ovf0_wrap_i | input | 1 | Counter-0 wrap past maximum pulse |
| ovf0_from_zero_i | input | 1 | Counter-0 advanced from zero pulse |
| cmp0_evt_i | input | 1 | Counter-0 compare match event pulse |
| pwm_mode_i | input | 1 | Counter 0 is in pulse-width-modulation mode |
| wr_en_i | input | 1 | Bus write strobe |
| wr_data_i | input | 8 | Bus write data; ones clear flags |
| rd_data_o | output | 8 | Flag read value, upper bits zero |
| ack_i | input | 4 | Per-source vector acknowledge |
| irq_o | output | 4 | Per-source interrupt requests |

## Verification
Event, write and acknowledge effects all go through one register stage, so they appear on `rd_data_o` after the next rising edge. The request outputs combine that flag state with the enables, which act within the same cycle. The bench changes its inputs 2 ns after a rising edge and waits for the following edge. It then compares both outputs against its own behavioural model 2 ns later, which is a full cycle after each stimulus. Enable-only changes are therefore visible in the cycle where they are applied.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  parameter int NUM_SRC = 4;
  parameter int BUS_W   = 8;

  // Bit positions; the vector decoder relies on this order.
  localparam int IDX_CMP0 = 0;
  localparam int IDX_OVF0 = 1;
  localparam int IDX_CMP2 = 2;
  localparam int IDX_CAP1 = 3;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/tmr_event_select.sv
module tmr_event_select
  import tmr_flag_pkg::*;
(
  input  logic     cap1_evt_i,
  input  logic     cmp2_evt_i,
  input  logic     ovf0_wrap_i,
  input  logic     ovf0_from_zero_i,
  input  logic     cmp0_evt_i,
  input  logic     pwm_mode_i,
  output src_vec_t set_o
);
  always_comb begin
    set_o           = '0;
    set_o[IDX_CAP1] = cap1_evt_i;
    set_o[IDX_CMP2] = cmp2_evt_i;
    // In PWM mode the overflow flag is tied to leaving zero, not to a wrap.
    set_o[IDX_OVF0] = pwm_mode_i ? ovf0_from_zero_i : ovf0_wrap_i;
    set_o[IDX_CMP0] = cmp0_evt_i;
  end
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic wr_clr_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)                    flag_q <= 1'b0;
    else if (set_i)             flag_q <= 1'b1;   // set has priority
    else if (wr_clr_i || ack_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);                                              // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !set_i) |=> !flag_o);                                 // R6
  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_clr_i && !set_i) |=> !flag_o);                              // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !wr_clr_i && !ack_i) |=> $stable(flag_o));           // R10
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags
  import tmr_flag_pkg::*;
#(
  parameter int N_SRC  = NUM_SRC,
  parameter int DATA_W = BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gie_i,
  input  logic [N_SRC-1:0]  src_en_i,
  input  logic              cap1_evt_i,
  input  logic              cmp2_evt_i,
  input  logic              ovf0_wrap_i,
  input  logic              ovf0_from_zero_i,
  input  logic              cmp0_evt_i,
  input  logic              pwm_mode_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [N_SRC-1:0]  ack_i,
  output logic [N_SRC-1:0]  irq_o
);
  localparam int PAD_W = DATA_W - N_SRC;

  src_vec_t         set_vec;
  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] wr_clr;

  tmr_event_select u_sel (
    .cap1_evt_i       (cap1_evt_i),
    .cmp2_evt_i       (cmp2_evt_i),
    .ovf0_wrap_i      (ovf0_wrap_i),
    .ovf0_from_zero_i (ovf0_from_zero_i),
    .cmp0_evt_i       (cmp0_evt_i),
    .pwm_mode_i       (pwm_mode_i),
    .set_o            (set_vec)
  );

  assign wr_clr = wr_en_i ? wr_data_i[N_SRC-1:0] : '0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    tmr_flag_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .set_i    (set_vec[g]),
      .wr_clr_i (wr_clr[g]),
      .ack_i    (ack_i[g]),
      .flag_o   (flags[g])
    );
  end

  assign rd_data_o = {{PAD_W{1'b0}}, flags};
  assign irq_o     = flags & src_en_i & {N_SRC{gie_i}};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (rd_data_o == '0));                                     // R1
  AST_PWM_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode_i && ovf0_from_zero_i) |=> rd_data_o[IDX_OVF0]);      // R4
  AST_WRAP_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (!pwm_mode_i && ovf0_wrap_i) |=> rd_data_o[IDX_OVF0]);          // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (irq_o & ~rd_data_o[N_SRC-1:0]) == '0);                         // R8
endmodule

// File: tb/timer_irq_flags_tb.sv
`timescale 1ns/1ps
module timer_irq_flags_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       gie_i;
  logic [3:0] src_en_i;
  logic       cap1_evt_i, cmp2_evt_i, ovf0_wrap_i, ovf0_from_zero_i, cmp0_evt_i;
  logic       pwm_mode_i;
  logic       wr_en_i;
  logic [7:0] wr_data_i;
  logic [7:0] rd_data_o;
  logic [3:0] ack_i;
  logic [3:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit model_f[4];

  always #10 clk = ~clk;   // 50 MHz

  timer_irq_flags u_dut (
    .clk(clk), .rst(rst), .gie_i(gie_i), .src_en_i(src_en_i),
    .cap1_evt_i(cap1_evt_i), .cmp2_evt_i(cmp2_evt_i),
    .ovf0_wrap_i(ovf0_wrap_i), .ovf0_from_zero_i(ovf0_from_zero_i),
    .cmp0_evt_i(cmp0_evt_i), .pwm_mode_i(pwm_mode_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .ack_i(ack_i), .irq_o(irq_o)
  );

  // Behavioural reference: per-bit set and clear rules from the requirements.
  always @(posedge clk) begin
    bit s[4];
    s[3] = cap1_evt_i;
    s[2] = cmp2_evt_i;
    s[1] = pwm_mode_i ? ovf0_from_zero_i : ovf0_wrap_i;
    s[0] = cmp0_evt_i;
    for (int i = 0; i < 4; i++) begin
      if (rst)                                  model_f[i] <= 1'b0;
      else if (s[i])                            model_f[i] <= 1'b1;
      else if (ack_i[i] || (wr_en_i && wr_data_i[i])) model_f[i] <= 1'b0;
    end
  end

  function automatic logic [7:0] exp_rd();
    logic [7:0] v = '0;
    for (int i = 0; i < 4; i++) v[i] = model_f[i];
    return v;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = model_f[i] & src_en_i[i] & gie_i;
    return v;
  endfunction

  task automatic compare(string req);
    checks++;
    if (rd_data_o !== exp_rd()) begin
      errors++;
      $display("FAIL %s rd_data actual=%h expected=%h", req, rd_data_o, exp_rd());
    end
    checks++;
    if (irq_o !== exp_irq()) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq_o, exp_irq());
    end
  endtask

  task automatic idle();
    cap1_evt_i = 0; cmp2_evt_i = 0; ovf0_wrap_i = 0; ovf0_from_zero_i = 0;
    cmp0_evt_i = 0; wr_en_i = 0; wr_data_i = '0; ack_i = '0;
  endtask

  // Inputs are set 2 ns after an edge; outputs are sampled 2 ns after the next edge.
  task automatic step(string req);
    @(posedge clk);
    #2;
    compare(req);
    idle();
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    rst = 1; gie_i = 1; src_en_i = 4'hF; pwm_mode_i = 0; idle();
    step("R1"); step("R1");
    rst = 0;
    step("R1 reset state");

    cap1_evt_i = 1; step("R2 capture bit3");
    cmp2_evt_i = 1; step("R2 compare2 bit2");
    cmp0_evt_i = 1; step("R2 compare0 bit0");
    step("R10 hold");

    ovf0_from_zero_i = 1; step("R3 from-zero ignored in normal mode");
    ovf0_wrap_i = 1; step("R3 wrap sets bit1");
    wr_en_i = 1; wr_data_i = 8'h02; step("R5 clear bit1");

    pwm_mode_i = 1;
    ovf0_wrap_i = 1; step("R4 wrap ignored in PWM");
    ovf0_from_zero_i = 1; step("R4 from-zero sets bit1");
    pwm_mode_i = 0;

    wr_en_i = 1; wr_data_i = 8'h00; step("R5 zero write no effect");
    wr_en_i = 1; wr_data_i = 8'hF0; step("R9 upper write no effect");
    checks++;
    if (rd_data_o[7:4] !== 4'h0) begin
      errors++; $display("FAIL R9 upper actual=%h expected=0", rd_data_o[7:4]);
    end

    wr_en_i = 1; wr_data_i = 8'h09; step("R5 clear bits 3 and 0");
    ack_i = 4'b0100; step("R6 ack clears bit2");
    ack_i = 4'b0010; step("R6 ack clears bit1");

    cmp0_evt_i = 1; wr_en_i = 1; wr_data_i = 8'h01; step("R7 set beats write");
    cap1_evt_i = 1; ack_i = 4'b1000; step("R7 set beats ack");
    cmp2_evt_i = 1; ack_i = 4'b0100; wr_en_i = 1; wr_data_i = 8'h04; step("R7 set beats both");

    src_en_i = 4'b0101; #1 compare("R8 partial enables");
    gie_i = 0; #1 compare("R8 global off");
    step("R8 global off held");
    gie_i = 1; src_en_i = 4'hF; #1 compare("R8 all enabled");

    for (int k = 0; k < 16; k++) begin
      ack_i = k[3:0]; cmp0_evt_i = k[0]; cap1_evt_i = k[2];
      src_en_i = ~k[3:0];
      step("R10 mixed pattern");
    end

    rst = 1; step("R1 second reset");
    rst = 0; step("R1 after second reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule